// File: doc/BRIEF.md
# CAN Interrupt Identifier Arbiter

This block picks the one interrupt that a message-object CAN controller reports to its CPU. Each message object contributes a pending flag. The protocol core contributes a pulse every time it writes the status register. From these the block builds a 16-bit identifier and drives one interrupt line. A status interrupt always outranks every message object. Among the objects, the lowest-numbered pending object is reported, and objects are numbered from 1.

A small register interface sits alongside. It holds the line enable and the two status-interrupt gates (one for error changes, one for status changes). It also supports reading the status register, which acknowledges the status interrupt, and CPU writes that overwrite the status fields. A command that names an object number together with a clear flag drops that object's pending flag. The identifier is derived combinationally from registered state. Any change to pending state is therefore visible in the cycle after the clock edge that stores it.

Top module: `can_int_arbiter`

## Requirements
- R1: After reset, and whenever neither the status interrupt nor any object is pending, `int_id_o` is 0 and `irq_o` is 0.
- R2: A gated status update makes `int_id_o` read 0x8000 in the next cycle, whatever objects are pending. This also happens when the loaded value equals the old one.
- R3: With no status interrupt, `int_id_o` equals k+1, where k is the lowest set bit of the object pending vector. Bit k is object k+1.
- R4: A status-register read (`stat_rd_i`) with no update in the same cycle clears the status interrupt. The identifier then falls to the next pending object, or to 0.
- R5: A command (`cmd_vld_i`) with `cmd_clr_i`=1 and object number n clears bit n-1 at the next edge. With `cmd_clr_i`=0 it has no effect. The identifier moves on to the next pending object or to 0.
- R6: `irq_o` is 1 exactly when the enable bit is set and `int_id_o` is nonzero. Clearing the enable drops the line in the next cycle.
- R7: `int_id_o` keeps tracking pending state while the enable bit is clear.
- R8: A CPU status write loads the status register. The layout is lec in bits [2:0], tx-ok in bit 3 and rx-ok in bit 4. The write never sets or clears the status interrupt.
- R9: An update with `stat_err_i`=1 raises the status interrupt only if the error gate is set. An update with `stat_err_i`=0 raises it only if the status gate is set. An ungated update still loads the register value.
- R10: A set pulse and a clear command on the same object in the same cycle leave that object pending.
- R11: A gated status update in the same cycle as a status-register read leaves the status interrupt pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| set_pend_i | input | NUM_OBJ | Per-object pending set pulses, bit k = object k+1 |
| cmd_vld_i | input | 1 | Object access command strobe |
| cmd_obj_i | input | OBJ_W | Object number 1..NUM_OBJ of the command |
| cmd_clr_i | input | 1 | Command clears the object's pending bit |
| ctrl_wr_i | input | 1 | Control write strobe |
| ctrl_ie_i | input | 1 | Interrupt line enable written |
| ctrl_eie_i | input | 1 | Error-change gate written |
| ctrl_sie_i | input | 1 | Status-change gate written |
| stat_upd_i | input | 1 | Protocol core status update pulse |
| stat_err_i | input | 1 | Update is an error change (1) or a status change (0) |
| stat_upd_val_i | input | 5 | Value loaded by the core update |
| stat_rd_i | input | 1 | CPU reads the status register |
| stat_wr_i | input | 1 | CPU write strobe to status register |
| stat_wr_val_i | input | 5 | CPU write value |
| stat_o | output | 5 | Status register contents |
| pend_o | output | NUM_OBJ | Registered object pending vector |
| int_id_o | output | 16 | Interrupt identifier |
| irq_o | output | 1 | Interrupt line to the CPU |

## Verification
The assertions check these behaviours on every cycle:
- a gated update raises the status interrupt, including when a read lands in the same cycle;
- a read on its own clears it;
- a CPU status write leaves it unchanged;
- a clear command with no competing set drops the object;
- the identifier is zero when nothing is pending;
- a disabled line goes low.

Only the bench scenarios can show the rest:
- the exact priority ordering across every pair of objects;
- the step-by-step walk of the identifier as objects are cleared in ascending and descending order;
- the error/status gate selection;
- identifier tracking while the line is disabled.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;
  localparam int ID_W = 16;
  localparam logic [ID_W-1:0] STATUS_ID = 16'h8000;

  typedef struct packed {
    logic       rx_ok;
    logic       tx_ok;
    logic [2:0] lec;
  } stat_t;
endpackage

// File: rtl/can_irq_pend_bank.sv
module can_irq_pend_bank #(
  parameter int NUM_OBJ = 32,
  parameter int OBJ_W   = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_OBJ-1:0] set_i,
  input  logic               clr_vld_i,
  input  logic [OBJ_W-1:0]   clr_obj_i,
  output logic [NUM_OBJ-1:0] pend_o
);
  for (genvar g = 0; g < NUM_OBJ; g++) begin : g_obj
    logic hit;
    assign hit = clr_vld_i && (clr_obj_i == OBJ_W'(g + 1));

    // set wins over a same-cycle clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       pend_o[g] <= 1'b0;
      else if (set_i[g]) pend_o[g] <= 1'b1;
      else if (hit)      pend_o[g] <= 1'b0;
    end

    assert_clr_drops_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit && !set_i[g] |=> !pend_o[g]);
    assert_set_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[g] |=> pend_o[g]);
  end
endmodule

// File: rtl/can_irq_prio_enc.sv
module can_irq_prio_enc #(
  parameter int NUM_OBJ = 32,
  parameter int ID_W    = 16
) (
  input  logic [NUM_OBJ-1:0] pend_i,
  output logic [ID_W-1:0]    id_o
);
  // scan downward so the lowest set bit is the last write
  always_comb begin
    id_o = '0;
    for (int i = NUM_OBJ - 1; i >= 0; i--) begin
      if (pend_i[i]) id_o = ID_W'(i + 1);
    end
  end
endmodule

// File: rtl/can_irq_stat.sv
module can_irq_stat import can_irq_pkg::*; (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  upd_i,
  input  logic  upd_err_i,
  input  stat_t upd_val_i,
  input  logic  rd_i,
  input  logic  wr_i,
  input  stat_t wr_val_i,
  input  logic  eie_i,
  input  logic  sie_i,
  output stat_t stat_o,
  output logic  pend_o
);
  logic gate;
  assign gate = upd_i && (upd_err_i ? eie_i : sie_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   stat_o <= '0;
    else if (upd_i) stat_o <= upd_val_i;
    else if (wr_i)  stat_o <= wr_val_i;
  end

  // core update beats a same-cycle read; CPU writes never touch pend_o
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   pend_o <= 1'b0;
    else if (gate) pend_o <= 1'b1;
    else if (rd_i) pend_o <= 1'b0;
  end

  assert_rd_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && !upd_i |=> !pend_o);
  assert_wr_keeps_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !upd_i && !rd_i |=> $stable(pend_o));
  assert_upd_wins_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i && rd_i && (upd_err_i ? eie_i : sie_i) |=> pend_o);
endmodule

// File: rtl/can_int_arbiter.sv
module can_int_arbiter import can_irq_pkg::*; #(
  parameter  int NUM_OBJ = 32,
  localparam int OBJ_W   = $clog2(NUM_OBJ + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_OBJ-1:0] set_pend_i,
  input  logic               cmd_vld_i,
  input  logic [OBJ_W-1:0]   cmd_obj_i,
  input  logic               cmd_clr_i,
  input  logic               ctrl_wr_i,
  input  logic               ctrl_ie_i,
  input  logic               ctrl_eie_i,
  input  logic               ctrl_sie_i,
  input  logic               stat_upd_i,
  input  logic               stat_err_i,
  input  logic [4:0]         stat_upd_val_i,
  input  logic               stat_rd_i,
  input  logic               stat_wr_i,
  input  logic [4:0]         stat_wr_val_i,
  output logic [4:0]         stat_o,
  output logic [NUM_OBJ-1:0] pend_o,
  output logic [ID_W-1:0]    int_id_o,
  output logic               irq_o
);
  logic            ie_q, eie_q, sie_q;
  logic            stat_pend;
  logic [ID_W-1:0] obj_id;
  stat_t           stat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ie_q  <= 1'b0;
      eie_q <= 1'b0;
      sie_q <= 1'b0;
    end else if (ctrl_wr_i) begin
      ie_q  <= ctrl_ie_i;
      eie_q <= ctrl_eie_i;
      sie_q <= ctrl_sie_i;
    end
  end

  can_irq_pend_bank #(.NUM_OBJ(NUM_OBJ), .OBJ_W(OBJ_W)) i_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (set_pend_i),
    .clr_vld_i (cmd_vld_i && cmd_clr_i),
    .clr_obj_i (cmd_obj_i),
    .pend_o    (pend_o)
  );

  can_irq_prio_enc #(.NUM_OBJ(NUM_OBJ), .ID_W(ID_W)) i_enc (
    .pend_i (pend_o),
    .id_o   (obj_id)
  );

  can_irq_stat i_stat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .upd_i     (stat_upd_i),
    .upd_err_i (stat_err_i),
    .upd_val_i (stat_t'(stat_upd_val_i)),
    .rd_i      (stat_rd_i),
    .wr_i      (stat_wr_i),
    .wr_val_i  (stat_t'(stat_wr_val_i)),
    .eie_i     (eie_q),
    .sie_i     (sie_q),
    .stat_o    (stat_q),
    .pend_o    (stat_pend)
  );

  assign stat_o   = stat_q;
  assign int_id_o = stat_pend ? STATUS_ID : obj_id;
  assign irq_o    = ie_q && (int_id_o != '0);

  assert_idle_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_pend && (pend_o == '0) |-> (int_id_o == '0) && !irq_o);
  assert_stat_top_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_upd_i && (stat_err_i ? eie_q : sie_q) |=> int_id_o == STATUS_ID);
  assert_line_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr_i && !ctrl_ie_i |=> !irq_o);
  assert_id_tracks_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_pend_i != '0) |=> int_id_o != '0);
endmodule

// File: tb/test_can_int_arbiter.sv
`timescale 1ns/1ps
module test_can_int_arbiter;
  localparam int N = 32;
  localparam int OW = 6;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [N-1:0]  set_pend_i = '0;
  logic          cmd_vld_i = 1'b0, cmd_clr_i = 1'b0;
  logic [OW-1:0] cmd_obj_i = '0;
  logic          ctrl_wr_i = 1'b0, ctrl_ie_i = 1'b0, ctrl_eie_i = 1'b0, ctrl_sie_i = 1'b0;
  logic          stat_upd_i = 1'b0, stat_err_i = 1'b0, stat_rd_i = 1'b0, stat_wr_i = 1'b0;
  logic [4:0]    stat_upd_val_i = '0, stat_wr_val_i = '0;
  logic [4:0]    stat_o;
  logic [N-1:0]  pend_o;
  logic [15:0]   int_id_o;
  logic          irq_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  can_int_arbiter #(.NUM_OBJ(N)) i_can_int_arbiter (.*);

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk_i); #1;
    set_pend_i = '0; cmd_vld_i = 0; cmd_clr_i = 0; ctrl_wr_i = 0;
    stat_upd_i = 0; stat_rd_i = 0; stat_wr_i = 0;
  endtask

  task automatic set_obj(input logic [N-1:0] m); set_pend_i = m; cyc(); endtask
  task automatic clr_obj(input int num, input bit flag);
    cmd_vld_i = 1; cmd_obj_i = OW'(num); cmd_clr_i = flag; cyc();
  endtask
  task automatic ctrl(input bit ie, input bit eie, input bit sie);
    ctrl_wr_i = 1; ctrl_ie_i = ie; ctrl_eie_i = eie; ctrl_sie_i = sie; cyc();
  endtask
  task automatic upd(input bit err, input logic [4:0] v);
    stat_upd_i = 1; stat_err_i = err; stat_upd_val_i = v; cyc();
  endtask
  task automatic rd(); stat_rd_i = 1; cyc(); endtask
  task automatic wr(input logic [4:0] v); stat_wr_i = 1; stat_wr_val_i = v; cyc(); endtask

  function automatic int lowest(input logic [N-1:0] m);
    for (int i = 0; i < N; i++) if (m[i]) return i + 1;
    return 0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got 0x0 expected 0x1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i); #1;
    rst_ni = 1;
    chk("R1 reset id", int_id_o, 0);
    chk("R1 reset irq", irq_o, 0);
    ctrl(1, 1, 1);

    // single objects: priority, line, clear with and without flag
    for (int k = 0; k < N; k++) begin
      set_obj(N'(1) << k);
      chk("R3 single", int_id_o, k + 1);
      chk("R6 line on", irq_o, 1);
      clr_obj(k + 1, 0);
      chk("R5 no flag", int_id_o, k + 1);
      clr_obj(k + 1, 1);
      chk("R5 cleared", int_id_o, 0);
      chk("R1 idle irq", irq_o, 0);
    end

    // all ordered pairs
    for (int a = 0; a < N; a++) begin
      for (int b = a; b < N; b++) begin
        set_obj((N'(1) << a) | (N'(1) << b));
        chk("R3 pair", int_id_o, a + 1);
        clr_obj(a + 1, 1);
        chk("R5 next", int_id_o, (a == b) ? 0 : b + 1);
        clr_obj(b + 1, 1);
        chk("R1 pair empty", int_id_o, 0);
      end
    end

    // ascending and descending walk through a full vector
    set_obj('1);
    for (int k = 0; k < N; k++) begin
      clr_obj(k + 1, 1);
      chk("R5 ascend", int_id_o, (k == N - 1) ? 0 : k + 2);
    end
    set_obj('1);
    for (int k = N - 1; k >= 0; k--) begin
      clr_obj(k + 1, 1);
      chk("R3 descend", int_id_o, (k == 0) ? 0 : 1);
    end

    // status interrupt over objects
    set_obj(N'(1) << 5);
    upd(0, 5'h07);
    chk("R2 status id", int_id_o, 32'h8000);
    chk("R2 status val", stat_o, 5'h07);
    rd();
    chk("R4 read clears", int_id_o, 6);
    upd(0, 5'h07);
    chk("R2 same value", int_id_o, 32'h8000);
    rd();
    chk("R4 read again", int_id_o, 6);

    // gate selection
    ctrl(1, 0, 1);
    upd(1, 5'h03);
    chk("R9 err gated off", int_id_o, 6);
    chk("R9 value loaded", stat_o, 5'h03);
    upd(0, 5'h08);
    chk("R9 status gate", int_id_o, 32'h8000);
    rd();
    ctrl(1, 1, 0);
    upd(0, 5'h10);
    chk("R9 status gated off", int_id_o, 6);
    upd(1, 5'h05);
    chk("R9 err gate", int_id_o, 32'h8000);

    // CPU writes
    wr(5'h00);
    chk("R8 write keeps int", int_id_o, 32'h8000);
    chk("R8 write value", stat_o, 5'h00);
    rd();
    chk("R4 after write", int_id_o, 6);
    wr(5'h1f);
    chk("R8 write no raise", int_id_o, 6);
    chk("R8 rx/tx/lec", stat_o, 5'h1f);

    // update and read in one cycle
    stat_upd_i = 1; stat_err_i = 1; stat_upd_val_i = 5'h02; stat_rd_i = 1; cyc();
    chk("R11 update wins", int_id_o, 32'h8000);
    rd();
    chk("R11 later read", int_id_o, 6);

    // enable off: identifier still tracks
    ctrl(0, 1, 1);
    chk("R6 line dropped", irq_o, 0);
    chk("R7 id kept", int_id_o, 6);
    clr_obj(6, 1);
    chk("R7 id cleared", int_id_o, 0);
    set_obj(N'(1) << 2);
    chk("R7 id new", int_id_o, 3);
    chk("R6 line gated", irq_o, 0);
    ctrl(1, 1, 1);
    chk("R6 line back", irq_o, 1);

    // set and clear in same cycle
    set_pend_i = N'(1) << 2; cmd_vld_i = 1; cmd_obj_i = 3; cmd_clr_i = 1; cyc();
    chk("R10 set wins held", int_id_o, 3);
    clr_obj(3, 1);
    set_pend_i = N'(1) << 2; cmd_vld_i = 1; cmd_obj_i = 3; cmd_clr_i = 1; cyc();
    chk("R10 set wins fresh", int_id_o, 3);
    chk("R10 pend bit", pend_o, lowest(pend_o) == 3 ? pend_o : 32'h0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule